// File: doc/BRIEF.md
# GPIO Bank Event Detector

This block watches a bank of general-purpose input pins and raises a single interrupt line for the whole bank. Every pin first passes through a synchroniser. The synchronised value is then compared against four per-pin enable masks that software owns: rising edge, falling edge, high level and low level. When a pin meets any condition it has enabled, its bit in a sticky status word is set. The interrupt output is high while any status bit is set.

Software uses a small word-addressed register bus. It programs the masks and reads the status word, which shows every pending pin at once. It acknowledges events by writing ones to the status word. An edge event that has been acknowledged stays clear until a new qualifying edge arrives. A level event comes back for as long as the pin stays at its enabled level. Double-edge detection comes from enabling both edge masks on the same pin. Two instances cover a system with more than 32 pins. The second instance leaves its unused pins tied off.

Top module: `pin_event_bank`

## Requirements
- R1: After reset, the status word and all four masks read as zero and `irqOut` is low.
- R2: The register bus uses these word offsets: 0 status, 1 rising mask, 2 falling mask, 3 high mask, 4 low mask. A mask write at offset 1 to 4 reads back unchanged. Offsets 5 to 7 read as zero, and writes to them change nothing.
- R3: A 0-to-1 transition on a pin whose rising-mask bit is 1 sets that pin's status bit. The bit is visible on the third rising clock edge after the pin changes, and a falling transition sets nothing when only the rising mask is set.
- R4: A 1-to-0 transition on a pin whose falling-mask bit is 1 sets its status bit with the same latency as R3. A rising transition sets nothing when only the falling mask is set.
- R5: A pin with both edge-mask bits set flags both its rising and its falling transitions.
- R6: A pin held high with its high-mask bit set, or held low with its low-mask bit set, sets its status bit.
- R7: Writing to offset 0 clears each status bit written as 1 and leaves each bit written as 0 unchanged. A set status bit stays set until it is cleared this way.
- R8: An edge-detected status bit that has been cleared stays clear while the pin holds its level, until a new qualifying edge occurs.
- R9: A level-detected status bit cannot be cleared while the pin remains at its enabled level.
- R10: If an event on a pin occurs in the same cycle as a write that clears that pin, the status bit stays set.
- R11: `irqOut` is high exactly when at least one status bit is set. Several pins can be pending together and are read together.
- R12: With all mask bits of a pin at zero, no activity on that pin sets its status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| regAddr | input | 3 | Register word offset |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | NUM_PINS | Write data |
| regRdData | output | NUM_PINS | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Bank interrupt, high while any status bit is set |

## Verification
The bench uses the default build: 32 pins and a two-stage synchroniser. At that width the lowest and highest pins, 0 and 31, can be pending at the same time, so the check on reading several pins together covers both ends of the word. With two synchroniser stages, the three-edge latency is a fixed number that the bench can test. This also makes it possible to place a clearing write on the exact edge where a new falling event lands.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 3'd0;
  localparam logic [REG_ADDR_W-1:0] OFS_RISE   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] OFS_FALL   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] OFS_HIGH   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] OFS_LOW    = 3'd4;

  // mask slot order inside the datapath
  localparam int MASK_RISE = 0;
  localparam int MASK_FALL = 1;
  localparam int MASK_HIGH = 2;
  localparam int MASK_LOW  = 3;
  localparam int MASK_KINDS = 4;

  typedef struct packed {
    logic clrStatus;
    logic ldLow;
    logic ldHigh;
    logic ldFall;
    logic ldRise;
  } regStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_RISE,
    RD_FALL,
    RD_HIGH,
    RD_LOW
  } rdSel_e;

endpackage

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  output regStrobes_t           strobes,
  output rdSel_e                rdSel
);

  always_comb begin
    strobes = '0;
    rdSel   = RD_NONE;
    case (regAddr)
      OFS_STATUS: begin
        rdSel = RD_STATUS;
        strobes.clrStatus = regWrEn;
      end
      OFS_RISE: begin
        rdSel = RD_RISE;
        strobes.ldRise = regWrEn;
      end
      OFS_FALL: begin
        rdSel = RD_FALL;
        strobes.ldFall = regWrEn;
      end
      OFS_HIGH: begin
        rdSel = RD_HIGH;
        strobes.ldHigh = regWrEn;
      end
      OFS_LOW: begin
        rdSel = RD_LOW;
        strobes.ldLow = regWrEn;
      end
      default: begin
        rdSel = RD_NONE;
      end
    endcase
  end

endmodule

// File: rtl/pin_event_dp.sv
module pin_event_dp
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_PINS-1:0]                  pinIn,
  input  regStrobes_t                          strobes,
  input  rdSel_e                               rdSel,
  input  logic [NUM_PINS-1:0]                  wrData,
  output logic [NUM_PINS-1:0]                  rdData,
  output logic [NUM_PINS-1:0]                  statusVec,
  output logic [NUM_PINS-1:0]                  eventVec,
  output logic [MASK_KINDS-1:0][NUM_PINS-1:0]  maskVec
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  // input synchroniser, a chain of SYNC_STAGES flops per pin
  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncChain;
  logic [NUM_PINS-1:0] syncNow;
  logic [NUM_PINS-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        syncChain[s] <= syncChain[s-1];
      end
    end
  end

  assign syncNow = syncChain[LAST_STAGE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncNow;
  end

  // four enable masks, one register each
  logic [MASK_KINDS-1:0] ldVec;
  assign ldVec = {strobes.ldLow, strobes.ldHigh, strobes.ldFall, strobes.ldRise};

  for (genvar k = 0; k < MASK_KINDS; k++) begin : g_mask
    logic [NUM_PINS-1:0] maskQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         maskQ <= '0;
      else if (ldVec[k]) maskQ <= wrData;
    end
    assign maskVec[k] = maskQ;
  end

  // detection
  logic [NUM_PINS-1:0] riseHit;
  logic [NUM_PINS-1:0] fallHit;
  logic [NUM_PINS-1:0] clrVec;

  assign riseHit  = syncNow & ~prevQ;
  assign fallHit  = ~syncNow & prevQ;
  assign eventVec = (riseHit  & maskVec[MASK_RISE]) |
                    (fallHit  & maskVec[MASK_FALL]) |
                    (syncNow  & maskVec[MASK_HIGH]) |
                    (~syncNow & maskVec[MASK_LOW]);

  assign clrVec = wrData & {NUM_PINS{strobes.clrStatus}};

  // sticky status: a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusVec <= '0;
    else       statusVec <= (statusVec & ~clrVec) | eventVec;
  end

  always_comb begin
    case (rdSel)
      RD_STATUS: rdData = statusVec;
      RD_RISE:   rdData = maskVec[MASK_RISE];
      RD_FALL:   rdData = maskVec[MASK_FALL];
      RD_HIGH:   rdData = maskVec[MASK_HIGH];
      RD_LOW:    rdData = maskVec[MASK_LOW];
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/pin_event_bank.sv
module pin_event_bank
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [NUM_PINS-1:0]   regWrData,
  output logic [NUM_PINS-1:0]   regRdData,
  output logic                  irqOut
);

  regStrobes_t strobes;
  rdSel_e      rdSel;
  logic [NUM_PINS-1:0] statusVec;
  logic [NUM_PINS-1:0] eventVec;
  logic [MASK_KINDS-1:0][NUM_PINS-1:0] maskVec;

  pin_event_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  pin_event_dp #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobes   (strobes),
    .rdSel     (rdSel),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .statusVec (statusVec),
    .eventVec  (eventVec),
    .maskVec   (maskVec)
  );

  assign irqOut = |statusVec;

endmodule

// File: rtl/pin_event_bank_chk.sv
module pin_event_bank_chk
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic [REG_ADDR_W-1:0]                regAddr,
  input logic                                 regWrEn,
  input logic [NUM_PINS-1:0]                  regWrData,
  input logic [NUM_PINS-1:0]                  regRdData,
  input logic                                 irqOut,
  input logic [NUM_PINS-1:0]                  statusVec,
  input logic [NUM_PINS-1:0]                  eventVec,
  input logic [MASK_KINDS-1:0][NUM_PINS-1:0]  maskVec
);

  logic clrHit;
  assign clrHit = regWrEn && (regAddr == OFS_STATUS);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqOut && statusVec == '0 && maskVec == '0));

  // R2
  rise_mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_RISE) |=> (maskVec[MASK_RISE] == $past(regWrData)));

  // R2
  low_mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_LOW) |=> (maskVec[MASK_LOW] == $past(regWrData)));

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrHit |=> ((statusVec & $past(regWrData) & ~$past(eventVec)) == '0));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusVec) & ~statusVec &
               ~($past(regWrData) & {NUM_PINS{$past(clrHit)}})) == '0));

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(eventVec) & ~statusVec) == '0));

  // R11
  irq_matches_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_STATUS) |-> (irqOut == (regRdData != '0)));

  // R12
  quiet_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((maskVec[0] | maskVec[1] | maskVec[2] | maskVec[3]) == '0)
      |=> ((statusVec & ~$past(statusVec)) == '0));

endmodule

bind pin_event_bank pin_event_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .statusVec (statusVec),
  .eventVec  (eventVec),
  .maskVec   (maskVec)
);

// File: tb/pin_event_bank_tb_top.sv
module pin_event_bank_tb_top;

  localparam int NP = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          rstN;
  logic [NP-1:0] pinVec;
  logic [2:0]    regAddr;
  logic          regWrEn;
  logic [NP-1:0] regWrData;
  wire  [NP-1:0] regRdData;
  wire           irqOut;

  pin_event_bank #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinVec),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  typedef struct {
    logic [NP-1:0] expData;
    logic          expIrq;
    string         tag;
  } scoreItem_t;

  scoreItem_t scoreQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // monitor: samples midway through the high phase after each rising edge
  initial begin
    scoreItem_t it;
    forever begin
      @(posedge clk);
      #5;
      if (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        total++;
        if (regRdData !== it.expData || irqOut !== it.expIrq) begin
          bad++;
          $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                   it.tag, regRdData, irqOut, it.expData, it.expIrq);
        end
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [NP-1:0] d,
                           input logic irq, input string tag);
    scoreItem_t it;
    @(negedge clk);
    regAddr = a;
    it.expData = d; it.expIrq = irq; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic setPin(input int idx, input logic v);
    @(negedge clk);
    pinVec[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] bitOf(input int i);
    return NP'(1) << i;
  endfunction

  initial begin
    rstN = 1'b0; pinVec = '0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg(3'd0, '0, 1'b0, "R1 status");
    expectReg(3'd1, '0, 1'b0, "R1 rise mask");
    expectReg(3'd4, '0, 1'b0, "R1 low mask");

    // R2 map and readback, pins all low
    regWrite(3'd1, 32'hA5A5_A5A5);
    regWrite(3'd2, 32'h5A5A_5A5A);
    regWrite(3'd3, 32'h0F0F_0F0F);
    regWrite(3'd7, 32'hFFFF_FFFF);
    expectReg(3'd1, 32'hA5A5_A5A5, 1'b0, "R2 rise readback");
    expectReg(3'd2, 32'h5A5A_5A5A, 1'b0, "R2 fall readback");
    expectReg(3'd3, 32'h0F0F_0F0F, 1'b0, "R2 high readback");
    expectReg(3'd7, '0, 1'b0, "R2 unmapped reads zero");
    expectReg(3'd5, '0, 1'b0, "R2 unmapped offset 5");
    expectReg(3'd0, '0, 1'b0, "R2 unmapped write ignored");
    regWrite(3'd4, 32'h00F0_0000);
    expectReg(3'd4, 32'h00F0_0000, 1'b1, "R2 low readback");
    // R6 low level on pins held low
    expectReg(3'd0, 32'h00F0_0000, 1'b1, "R6 low level");
    regWrite(3'd1, '0); regWrite(3'd2, '0); regWrite(3'd3, '0); regWrite(3'd4, '0);
    regWrite(3'd0, 32'hFFFF_FFFF);
    expectReg(3'd0, '0, 1'b0, "R7 clear all");

    // R12 no masks, pin activity ignored
    setPin(3, 1'b1);
    setPin(3, 1'b0);
    expectReg(3'd0, '0, 1'b0, "R12 unmasked pin");

    // R3 rising edge, R8 edge stays clear
    regWrite(3'd1, bitOf(2));
    setPin(2, 1'b1);
    expectReg(3'd0, bitOf(2), 1'b1, "R3 rise sets");
    regWrite(3'd0, bitOf(2));
    expectReg(3'd0, '0, 1'b0, "R8 edge cleared");
    repeat (4) @(negedge clk);
    expectReg(3'd0, '0, 1'b0, "R8 edge stays clear");
    setPin(2, 1'b0);
    expectReg(3'd0, '0, 1'b0, "R3 fall ignored on rise mask");
    setPin(2, 1'b1);
    expectReg(3'd0, bitOf(2), 1'b1, "R8 new edge sets again");
    regWrite(3'd0, bitOf(2));
    regWrite(3'd1, '0);

    // R4 falling edge and latency
    regWrite(3'd2, bitOf(4));
    setPin(4, 1'b1);
    expectReg(3'd0, '0, 1'b0, "R4 rise ignored on fall mask");
    @(negedge clk);
    pinVec[4] = 1'b0;
    expectReg(3'd0, '0, 1'b0, "R4 not before third edge");
    expectReg(3'd0, bitOf(4), 1'b1, "R4 fall sets");
    regWrite(3'd0, bitOf(4));
    regWrite(3'd2, '0);

    // R5 both edges, R10 clash of fall event and clear
    regWrite(3'd1, bitOf(5));
    regWrite(3'd2, bitOf(5));
    setPin(5, 1'b1);
    expectReg(3'd0, bitOf(5), 1'b1, "R5 rise on double edge");
    @(negedge clk);
    pinVec[5] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    regAddr = 3'd0; regWrData = bitOf(5); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    expectReg(3'd0, bitOf(5), 1'b1, "R10 event beats clear");
    regWrite(3'd0, bitOf(5));
    expectReg(3'd0, '0, 1'b0, "R7 clear after clash");
    setPin(5, 1'b1);
    regWrite(3'd0, bitOf(5));
    setPin(5, 1'b0);
    expectReg(3'd0, bitOf(5), 1'b1, "R5 fall on double edge");
    regWrite(3'd0, bitOf(5));
    regWrite(3'd1, '0); regWrite(3'd2, '0);

    // R6 high level, R9 level re-asserts
    regWrite(3'd3, bitOf(9));
    setPin(9, 1'b1);
    expectReg(3'd0, bitOf(9), 1'b1, "R6 high level");
    regWrite(3'd0, bitOf(9));
    expectReg(3'd0, bitOf(9), 1'b1, "R9 level persists");
    setPin(9, 1'b0);
    expectReg(3'd0, bitOf(9), 1'b1, "R7 sticky after level gone");
    regWrite(3'd0, bitOf(9));
    expectReg(3'd0, '0, 1'b0, "R7 level cleared");
    regWrite(3'd3, '0);

    // R11 several pins pending, R7 zero write
    regWrite(3'd1, bitOf(0) | bitOf(31));
    @(negedge clk);
    pinVec[0] = 1'b1; pinVec[31] = 1'b1;
    repeat (3) @(negedge clk);
    expectReg(3'd0, bitOf(0) | bitOf(31), 1'b1, "R11 two pins pending");
    regWrite(3'd0, '0);
    expectReg(3'd0, bitOf(0) | bitOf(31), 1'b1, "R7 zero write keeps bits");
    regWrite(3'd0, bitOf(0));
    expectReg(3'd0, bitOf(31), 1'b1, "R11 irq with one left");
    regWrite(3'd0, bitOf(31));
    expectReg(3'd0, '0, 1'b0, "R11 irq drops");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule